// File: doc/BRIEF.md
# Counter-Triggered Taken-Branch Sampler

This block counts pulses of a chosen retire event against a programmed period. While it counts, taken branches pass by unrecorded. When the count wraps, it arms a small store. After an optional number of skipped branches, the store records the source and target address of every taken branch, whatever its kind. It stops taking records once it is full, and only then raises its interrupt. Software reads the records back by index, newest first. It then issues a clear pulse, which empties the store and starts a fresh period.

The period register refuses any value that is not larger than the store depth. The event counter keeps advancing while the store fills. A clear pulse, or a new period that is accepted, returns the block to counting.

Top module: `taken_branch_sampler`

## Requirements
- R1: The store holds DEPTH (default 16) records. Once it holds DEPTH records, further taken branches are dropped and the stored records are left unchanged. Entry DEPTH-1 keeps the oldest captured branch.
- R2: While capture is active, every cycle with `br_vld_i` high adds one record, including branches in back-to-back cycles.
- R3: Capture starts in the cycle after the event pulse that completes the programmed period P.
  - Branches seen before that event are not recorded.
  - A branch in the same cycle as that event is not recorded.
  - Branches seen after that event are recorded.
- R4: `irq_o` stays low at counter overflow and while the store is filling. It rises in the cycle after the DEPTH-th record is taken and stays high until a clear or an accepted period write.
- R5: A period write with a value of DEPTH or less is rejected.
  - `cfg_err_o` is high for one cycle after the write.
  - The block's state, the stored records and the previously accepted period are left unchanged.
  - An accepted write gives `cfg_err_o` = 0.
- R6: A read at index `rd_idx_i` returns the captured records newest first: entry 0 is the most recent and higher indices are older.
  - `rd_valid_o` is 1 only for an index below the number of records held.
  - For any other index, `rd_src_o` and `rd_dst_o` read 0.
- R7: After overflow, the first SKID (parameter, default 0) taken branches are not recorded. Capture begins with the branch that follows them.
- R8: After reset, nothing is captured and `irq_o` is 0 until a period is accepted. A clear pulse empties the store, drops `irq_o` and reloads the counter with the last accepted period, so that a new full period is counted before capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Retire-event pulse that is counted against the period |
| br_vld_i | input | 1 | Taken-branch strobe |
| br_src_i | input | ADDR_W | Branch source address |
| br_dst_i | input | ADDR_W | Branch target address |
| cfg_we_i | input | 1 | Period write strobe, which also restarts counting |
| cfg_period_i | input | CNT_W | Requested sampling period |
| cfg_err_o | output | 1 | One-cycle flag that a period write was rejected |
| clr_i | input | 1 | Software clear pulse |
| rd_idx_i | input | IDX_W | Read index, where 0 is the newest record |
| rd_valid_o | output | 1 | The indexed entry holds a record |
| rd_src_o | output | ADDR_W | Source address of the indexed record |
| rd_dst_o | output | ADDR_W | Target address of the indexed record |
| irq_o | output | 1 | Store-full interrupt |

## Verification
The bench places a branch in the same cycle as the event that ends the period, which checks that capture is armed one cycle late. A design that armed immediately would record that branch, and every later entry would shift by one. It fills the store exactly to its depth and then sends four more branches. A store that wrapped would replace the oldest entry, and one that raised the interrupt early would show it after fifteen records. Period values at the depth boundary and a period of one hundred find off-by-one errors in the reject compare and the two's-complement load. A second instance with three skipped branches checks that the skid counter neither captures the skipped branches nor loses the branch after them.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_COUNT = 3'd1,
      ST_SKID  = 3'd2,
      ST_CAPT  = 3'd3,
      ST_FULL  = 3'd4
   } tbs_state_e;
endpackage

// File: rtl/tbs_period_ctr.sv
// Event counter: loaded with minus the period, wraps to zero on overflow.
module tbs_period_ctr #(
   parameter int CNT_W = 32,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             cfg_we_i,
   input  logic [CNT_W-1:0] cfg_period_i,
   input  logic             clr_i,
   output logic             accept_o,
   output logic             armed_o,
   output logic             ovf_o,
   output logic             cfg_err_o
);
   localparam logic [CNT_W-1:0] MinPeriod = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] AllOnes   = '1;

   logic [CNT_W-1:0] period_q, cnt_q;
   logic             armed_q, err_q;
   logic             reload;

   assign accept_o = cfg_we_i && (cfg_period_i > MinPeriod);
   assign reload   = clr_i && armed_q && !accept_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         cnt_q    <= '0;
         armed_q  <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         err_q <= cfg_we_i && !accept_o;
         if (accept_o) begin
            period_q <= cfg_period_i;
            cnt_q    <= '0 - cfg_period_i;
            armed_q  <= 1'b1;
         end else if (reload) begin
            cnt_q <= '0 - period_q;
         end else if (armed_q && evt_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign armed_o   = armed_q;
   assign cfg_err_o = err_q;
   assign ovf_o     = armed_q && evt_i && (cnt_q == AllOnes) && !accept_o && !clr_i;

   // R5: a rejected write leaves the stored period alone
   p_reject_keeps_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && !accept_o) |=> $stable(period_q));
   // R5: error flag only follows a write
   p_err_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> $past(cfg_we_i));
   // R8: the counter is only loaded with an accepted period
   p_period_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (period_q > MinPeriod));
endmodule

// File: rtl/tbs_capture_seq.sv
// Sequencer: idle -> count -> (skid) -> capture -> full.
module tbs_capture_seq
   import tbs_pkg::*;
#(
   parameter  int DEPTH  = 16,
   parameter  int SKID   = 0,
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              stop_i,
   input  logic              ovf_i,
   input  logic              br_vld_i,
   output tbs_state_e        state_o,
   output logic [FILL_W-1:0] fill_o,
   output logic              wr_en_o
);
   localparam logic [FILL_W-1:0] LastSlot = FILL_W'(DEPTH - 1);
   localparam logic [FILL_W-1:0] Full     = FILL_W'(DEPTH);

   tbs_state_e        state_q, state_d;
   logic [FILL_W-1:0] fill_q, fill_d;
   logic              skid_done;

   generate
      if (SKID > 0) begin : g_skid
         localparam int SK_W = $clog2(SKID + 1);
         logic [SK_W-1:0] sk_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  sk_q <= '0;
            else if (state_q != ST_SKID) sk_q <= '0;
            else if (br_vld_i)           sk_q <= sk_q + 1'b1;
         end
         assign skid_done = (state_q == ST_SKID) && br_vld_i && (sk_q == SK_W'(SKID - 1));
         // R7: the skip count never runs past SKID
         p_skid_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_SKID) |-> (sk_q < SK_W'(SKID)));
      end else begin : g_noskid
         assign skid_done = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      fill_d  = fill_q;
      if (restart_i) begin
         state_d = ST_COUNT;
         fill_d  = '0;
      end else if (stop_i) begin
         state_d = ST_IDLE;
         fill_d  = '0;
      end else begin
         case (state_q)
            ST_COUNT: if (ovf_i) state_d = (SKID == 0) ? ST_CAPT : ST_SKID;
            ST_SKID:  if (skid_done) state_d = ST_CAPT;
            ST_CAPT: begin
               if (br_vld_i) begin
                  fill_d = fill_q + 1'b1;
                  if (fill_q == LastSlot) state_d = ST_FULL;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fill_q  <= '0;
      end else begin
         state_q <= state_d;
         fill_q  <= fill_d;
      end
   end

   assign state_o = state_q;
   assign fill_o  = fill_q;
   assign wr_en_o = (state_q == ST_CAPT) && br_vld_i && !restart_i && !stop_i;

   // R1: fill level saturates at the depth
   p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= Full);
   // R1: a full store ignores branches until cleared
   p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FULL && !restart_i && !stop_i) |=> (state_q == ST_FULL && $stable(fill_q)));
   // R3: nothing is recorded while counting
   p_count_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COUNT) |-> (fill_q == '0));
   // R3: overflow leaves the counting state
   p_ovf_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COUNT && ovf_i && !restart_i && !stop_i) |=> (state_q != ST_COUNT));
   // R4: overflow itself does not reach the full state
   p_ovf_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COUNT && ovf_i) |=> (state_q != ST_FULL));
   // R4: the full state means a full store
   p_full_means_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FULL) |-> (fill_q == Full));
endmodule

// File: rtl/tbs_branch_store.sv
// Saturating record store with newest-first indexed readout.
module tbs_branch_store #(
   parameter  int DEPTH  = 16,
   parameter  int ADDR_W = 64,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [FILL_W-1:0] fill_i,
   input  logic [ADDR_W-1:0] src_i,
   input  logic [ADDR_W-1:0] dst_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic              rd_valid_o,
   output logic [ADDR_W-1:0] rd_src_o,
   output logic [ADDR_W-1:0] rd_dst_o
);
   logic [DEPTH-1:0][ADDR_W-1:0] src_q, dst_q;
   logic [DEPTH-1:0]             slot_we;
   logic [IDX_W-1:0]             slot;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_we
         assign slot_we[i] = wr_en_i && (fill_i == FILL_W'(i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) begin
               src_q[i] <= src_i;
               dst_q[i] <= dst_i;
            end
         end
      end
   end

   assign rd_valid_o = FILL_W'(rd_idx_i) < fill_i;
   assign slot       = IDX_W'(fill_i - FILL_W'(1) - FILL_W'(rd_idx_i));
   assign rd_src_o   = rd_valid_o ? src_q[slot] : '0;
   assign rd_dst_o   = rd_valid_o ? dst_q[slot] : '0;

   // R1: no write once every slot is used
   p_no_overwrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |-> (fill_i < FILL_W'(DEPTH)));
   // R1: at most one slot written per cycle
   p_one_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_we));
endmodule

// File: rtl/taken_branch_sampler.sv
module taken_branch_sampler
   import tbs_pkg::*;
#(
   parameter  int DEPTH  = 16,
   parameter  int ADDR_W = 64,
   parameter  int CNT_W  = 32,
   parameter  int SKID   = 0,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              br_vld_i,
   input  logic [ADDR_W-1:0] br_src_i,
   input  logic [ADDR_W-1:0] br_dst_i,
   input  logic              cfg_we_i,
   input  logic [CNT_W-1:0]  cfg_period_i,
   output logic              cfg_err_o,
   input  logic              clr_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic              rd_valid_o,
   output logic [ADDR_W-1:0] rd_src_o,
   output logic [ADDR_W-1:0] rd_dst_o,
   output logic              irq_o
);
   generate
      if (DEPTH < 2)             begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (SKID < 0)              begin : g_bad_skid  $error("SKID must not be negative"); end
      if (CNT_W <= FILL_W)       begin : g_bad_cnt   $error("CNT_W too small for DEPTH"); end
      if (ADDR_W < 1)            begin : g_bad_addr  $error("ADDR_W must be positive"); end
   endgenerate

   logic              accept, armed, ovf, restart, stop, wr_en;
   logic [FILL_W-1:0] fill;
   tbs_state_e        state;

   tbs_period_ctr #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_ctr (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (evt_i),
      .cfg_we_i     (cfg_we_i),
      .cfg_period_i (cfg_period_i),
      .clr_i        (clr_i),
      .accept_o     (accept),
      .armed_o      (armed),
      .ovf_o        (ovf),
      .cfg_err_o    (cfg_err_o)
   );

   assign restart = accept || (clr_i && armed);
   assign stop    = clr_i && !armed;

   tbs_capture_seq #(.DEPTH(DEPTH), .SKID(SKID)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .stop_i    (stop),
      .ovf_i     (ovf),
      .br_vld_i  (br_vld_i),
      .state_o   (state),
      .fill_o    (fill),
      .wr_en_o   (wr_en)
   );

   tbs_branch_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en),
      .fill_i     (fill),
      .src_i      (br_src_i),
      .dst_i      (br_dst_i),
      .rd_idx_i   (rd_idx_i),
      .rd_valid_o (rd_valid_o),
      .rd_src_o   (rd_src_o),
      .rd_dst_o   (rd_dst_o)
   );

   assign irq_o = (state == ST_FULL);

   // R8: a clear drops the interrupt on the next cycle
   p_clear_drops_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !irq_o);
   // R8: nothing captured before a period was accepted
   p_idle_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (fill == '0 && !irq_o));
   // R4: interrupt rises only from a store holding DEPTH-1 records plus a branch
   p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(fill) == FILL_W'(DEPTH - 1) && $past(br_vld_i)));
endmodule

// File: tb/sim_taken_branch_sampler.sv
`timescale 1ns/1ps
module sim_taken_branch_sampler;
   localparam int DEPTH = 16;
   localparam int AW    = 64;
   localparam int CW    = 32;
   localparam logic [AW-1:0] SRC_BASE = 64'h1000_0000_0000_0000;
   localparam logic [AW-1:0] DST_BASE = 64'h2000_0000_0000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt = 1'b0, br_vld = 1'b0, cfg_we = 1'b0, clr = 1'b0;
   logic [AW-1:0] br_src = '0, br_dst = '0;
   logic [CW-1:0] cfg_period = '0;
   logic [3:0]    rd_idx = '0;
   logic          err0, err1, vld0, vld1, irq0, irq1;
   logic [AW-1:0] src0, dst0, src1, dst1;

   int n_chk = 0, n_fail = 0, brn = 0;
   bit done = 0;

   always #2 clk = ~clk;

   taken_branch_sampler u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .br_vld_i(br_vld), .br_src_i(br_src),
      .br_dst_i(br_dst), .cfg_we_i(cfg_we), .cfg_period_i(cfg_period), .cfg_err_o(err0),
      .clr_i(clr), .rd_idx_i(rd_idx), .rd_valid_o(vld0), .rd_src_o(src0), .rd_dst_o(dst0),
      .irq_o(irq0));

   taken_branch_sampler #(.SKID(3)) u1 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .br_vld_i(br_vld), .br_src_i(br_src),
      .br_dst_i(br_dst), .cfg_we_i(cfg_we), .cfg_period_i(cfg_period), .cfg_err_o(err1),
      .clr_i(clr), .rd_idx_i(rd_idx), .rd_valid_o(vld1), .rd_src_o(src1), .rd_dst_o(dst1),
      .irq_o(irq1));

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // one cycle with an optional event and an optional branch
   task automatic step(input bit e, input bit b);
      evt = e;
      br_vld = b;
      if (b) begin
         br_src = SRC_BASE + AW'(brn);
         br_dst = DST_BASE + AW'(brn);
         brn++;
      end
      tick();
      evt = 1'b0;
      br_vld = 1'b0;
   endtask

   task automatic wr_period(input int p);
      cfg_we = 1'b1;
      cfg_period = CW'(p);
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic do_clear();
      clr = 1'b1;
      tick();
      clr = 1'b0;
   endtask

   task automatic peek(input int idx);
      rd_idx = 4'(idx);
      #0.5;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      peek(0);
      chk("R8 reset irq", AW'(irq0), 0);
      chk("R8 reset entry0 valid", AW'(vld0), 0);
      chk("R8 reset err", AW'(err0), 0);
      for (int i = 0; i < 30; i++) step(1, 1);
      peek(0);
      chk("R8 idle no capture", AW'(vld0), 0);
      chk("R8 idle no irq", AW'(irq0), 0);
   endtask

   task automatic t_reject_idle();
      wr_period(DEPTH);
      chk("R5 period 16 rejected", AW'(err0), 1);
      for (int i = 0; i < 40; i++) step(1, 1);
      peek(0);
      chk("R5 rejected stays idle valid", AW'(vld0), 0);
      chk("R5 rejected stays idle irq", AW'(irq0), 0);
   endtask

   task automatic t_main();
      int b0;
      wr_period(20);
      chk("R5 period 20 accepted", AW'(err0), 0);
      brn = 0;
      for (int i = 0; i < 19; i++) step(1, 1);
      peek(0);
      chk("R3 no capture before period", AW'(vld0), 0);
      step(1, 1);  // completing event with a branch in the same cycle
      peek(0);
      chk("R3 overflow-cycle branch dropped", AW'(vld0), 0);
      chk("R4 no irq at overflow", AW'(irq0), 0);
      b0 = brn;
      for (int i = 0; i < 15; i++) step(i[0], 1);
      chk("R4 no irq at 15 records", AW'(irq0), 0);
      peek(14);
      chk("R6 entry14 valid", AW'(vld0), 1);
      peek(15);
      chk("R6 entry15 empty", AW'(vld0), 0);
      chk("R6 empty entry reads zero", src0, 0);
      step(0, 1);
      chk("R4 irq at 16 records", AW'(irq0), 1);
      chk("R7 skid instance not yet full", AW'(irq1), 0);
      for (int i = 0; i < 4; i++) step(1, 1);
      chk("R7 skid instance full", AW'(irq1), 1);
      chk("R4 irq held", AW'(irq0), 1);
      for (int i = 0; i < DEPTH; i++) begin
         peek(i);
         chk($sformatf("R6 R2 entry%0d src", i), src0, SRC_BASE + AW'(b0 + 15 - i));
         chk($sformatf("R6 entry%0d dst", i), dst0, DST_BASE + AW'(b0 + 15 - i));
         chk($sformatf("R7 skid entry%0d src", i), src1, SRC_BASE + AW'(b0 + 18 - i));
      end
      peek(15);
      chk("R1 oldest kept, no overwrite", src0, SRC_BASE + AW'(b0));
   endtask

   task automatic t_clear();
      int b0;
      wr_period(5);
      chk("R5 period 5 rejected", AW'(err0), 1);
      chk("R5 rejected write keeps irq", AW'(irq0), 1);
      peek(0);
      chk("R5 rejected write keeps data", AW'(vld0), 1);
      do_clear();
      peek(0);
      chk("R8 clear drops irq", AW'(irq0), 0);
      chk("R8 clear empties", AW'(vld0), 0);
      for (int i = 0; i < 19; i++) step(1, 0);
      step(0, 1);
      peek(0);
      chk("R8 reloaded period not elapsed", AW'(vld0), 0);
      step(1, 0);
      b0 = brn;
      for (int i = 0; i < DEPTH; i++) step(0, 1);
      chk("R8 refill irq", AW'(irq0), 1);
      peek(0);
      chk("R8 refill newest", src0, SRC_BASE + AW'(b0 + 15));
   endtask

   task automatic t_long_period();
      wr_period(100);
      chk("R5 period 100 accepted", AW'(err0), 0);
      chk("R3 new period drops irq", AW'(irq0), 0);
      for (int i = 0; i < 99; i++) step(1, 0);
      step(0, 1);
      peek(0);
      chk("R3 99 of 100 no capture", AW'(vld0), 0);
      step(1, 0);
      step(0, 1);
      peek(0);
      chk("R3 capture after 100th", AW'(vld0), 1);
      chk("R3 captured address", src0, SRC_BASE + AW'(brn - 1));
      peek(1);
      chk("R3 only one record", AW'(vld0), 0);
   endtask

   task automatic t_min_period();
      wr_period(DEPTH + 1);
      chk("R5 period 17 accepted", AW'(err0), 0);
      for (int i = 0; i < DEPTH + 1; i++) step(1, 0);
      step(0, 1);
      peek(0);
      chk("R3 period 17 capture", AW'(vld0), 1);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_reject_idle();
      t_main();
      t_clear();
      t_long_period();
      t_min_period();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule